// File: doc/BRIEF.md
# Adjustable 24-Hour Time-of-Day Counter

The block keeps time of day as hours, minutes and seconds, driven from a fast system clock. A parameterised prescaler turns the system clock into a one-cycle second tick. That tick steps the seconds field. Each field passes a carry to the next field in exactly the cycle in which it wraps.

Any single field can be stepped by hand. A two-bit select input picks the field, and one-cycle plus and minus pulses move it up or down by one. For every field the block outputs the binary value and also a tens digit and a units digit, ready for a display decoder. A parameter can turn the whole chain into a down counter, which gives a countdown of the same format.

Top module: `tod_counter`

## Requirements
- R1: While `rst_n` is low, and on the first sample after reset, every field and every digit output is 0.
- R2: The seconds field steps once every `TICK_DIV` clock cycles. The first step happens on the first rising edge after reset is released, because the prescaler count starts at 0 and the tick is issued when that count is 0.
- R3: Minutes step only on a tick cycle in which seconds wrap from their terminal value. Hours step only in the cycle in which minutes wrap. Counting up, 23:59:59 is followed by 00:00:00.
- R4: The field selected by `adj_sel` (0 = seconds, 1 = minutes, 2 = hours) gains one on an `adj_plus` pulse. It loses one on an `adj_minus` pulse. The maximum plus one gives 0, and 0 minus one gives the maximum (59, 59, 23).
- R5: Plus and minus asserted together leave the selected field as it is. With `adj_sel` = 3, the adjust pulses reach no field, and all fields follow the tick alone.
- R6: An adjust pulse has priority over the tick on the selected field. A field that is being adjusted never passes a carry or borrow to the next field.
- R7: With `COUNT_UP` = 0, every field counts down on the tick. A field at 0 goes to its maximum on a tick, and that borrow steps the next field down. The first tick after reset therefore shows 23:59:59.
- R8: Each tens digit equals the field value divided by 10, and each units digit equals the field value modulo 10.
- R9: Seconds and minutes never exceed 59, and hours never exceed 23.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is expected to be synchronous to `clk` |
| adj_sel | input | 2 | Field chosen for adjustment: 0 seconds, 1 minutes, 2 hours, 3 none |
| adj_plus | input | 1 | One-cycle pulse: add one to the selected field |
| adj_minus | input | 1 | One-cycle pulse: subtract one from the selected field |
| hours | output | 5 | Binary hours, 0 to 23 |
| minutes | output | 6 | Binary minutes, 0 to 59 |
| seconds | output | 6 | Binary seconds, 0 to 59 |
| hour_tens | output | 4 | Tens digit of hours |
| hour_units | output | 4 | Units digit of hours |
| min_tens | output | 4 | Tens digit of minutes |
| min_units | output | 4 | Units digit of minutes |
| sec_tens | output | 4 | Tens digit of seconds |
| sec_units | output | 4 | Units digit of seconds |

## Verification
The hardest case to reach from the ports is an adjust pulse that lands on a field in the same cycle in which the tick would make that field wrap. Only then does the priority rule decide whether a carry is lost. Reaching the day boundary is just as awkward.

The bench uses a four-cycle prescaler and runs an up-counting instance and a down-counting instance side by side. It first uses adjust pulses to drive the fields to 23:59:57, then lets them run across midnight. After that, a long pseudo-random stretch of select, plus and minus inputs collides with ticks at every field value. An arithmetic time model predicts every output after every edge.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam logic [1:0] SEL_SEC  = 2'd0;
  localparam logic [1:0] SEL_MIN  = 2'd1;
  localparam logic [1:0] SEL_HOUR = 2'd2;
  localparam logic [1:0] SEL_NONE = 2'd3;

  localparam int SEC_MAX  = 59;
  localparam int MIN_MAX  = 59;
  localparam int HOUR_MAX = 23;
  localparam int DIGIT_W  = 4;
endpackage

// File: rtl/tod_prescaler.sv
module tod_prescaler #(
  parameter int DIV = 50_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/tod_field.sv
module tod_field #(
  parameter int MAX = 59,
  parameter bit UP  = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       step_en,
  input  logic                       plus,
  input  logic                       minus,
  output logic [$clog2(MAX+1)-1:0]   value,
  output logic                       carry
);
  localparam int W = $clog2(MAX + 1);
  localparam logic [W-1:0] TOP = W'(MAX);

  logic [W-1:0] val_q, val_d, inc_v, dec_v;
  logic         at_top, at_zero, idle;

  assign at_top  = (val_q == TOP);
  assign at_zero = (val_q == '0);
  assign inc_v   = at_top  ? '0  : val_q + 1'b1;
  assign dec_v   = at_zero ? TOP : val_q - 1'b1;
  assign idle    = !plus && !minus;

  always_comb begin
    val_d = val_q;
    if (plus && !minus)       val_d = inc_v;
    else if (minus && !plus)  val_d = dec_v;
    else if (idle && step_en) val_d = UP ? inc_v : dec_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) val_q <= '0;
    else        val_q <= val_d;
  end

  assign value = val_q;
  assign carry = step_en && idle && (UP ? at_top : at_zero);
endmodule

// File: rtl/tod_digits.sv
module tod_digits #(
  parameter int W = 6
) (
  input  logic [W-1:0] value,
  output logic [3:0]   tens,
  output logic [3:0]   units
);
  logic [7:0] ext, t8, u8;

  assign ext   = 8'(value);
  assign t8    = ext / 8'd10;
  assign u8    = ext % 8'd10;
  assign tens  = t8[3:0];
  assign units = u8[3:0];
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int TICK_DIV = 50_000_000,
  parameter bit COUNT_UP = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] adj_sel,
  input  logic       adj_plus,
  input  logic       adj_minus,
  output logic [4:0] hours,
  output logic [5:0] minutes,
  output logic [5:0] seconds,
  output logic [3:0] hour_tens,
  output logic [3:0] hour_units,
  output logic [3:0] min_tens,
  output logic [3:0] min_units,
  output logic [3:0] sec_tens,
  output logic [3:0] sec_units
);
  localparam int NF = 3;
  localparam int FMAX [NF] = '{SEC_MAX, MIN_MAX, HOUR_MAX};
  localparam logic [1:0] FSEL [NF] = '{SEL_SEC, SEL_MIN, SEL_HOUR};

  logic          sec_tick;
  logic [NF:0]   chain;
  logic [5:0]    fval  [NF];
  logic [3:0]    ftens [NF];
  logic [3:0]    funits[NF];

  tod_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(sec_tick)
  );

  assign chain[0] = sec_tick;

  for (genvar f = 0; f < NF; f++) begin : g_field
    localparam int FW = $clog2(FMAX[f] + 1);
    logic          hit;
    logic [FW-1:0] v;

    assign hit = (adj_sel == FSEL[f]);

    tod_field #(.MAX(FMAX[f]), .UP(COUNT_UP)) u_fld (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (chain[f]),
      .plus    (hit && adj_plus),
      .minus   (hit && adj_minus),
      .value   (v),
      .carry   (chain[f+1])
    );

    tod_digits #(.W(FW)) u_dig (
      .value(v), .tens(ftens[f]), .units(funits[f])
    );

    assign fval[f] = 6'(v);
  end

  assign seconds    = fval[0];
  assign minutes    = fval[1];
  assign hours      = fval[2][4:0];
  assign sec_tens   = ftens[0];
  assign sec_units  = funits[0];
  assign min_tens   = ftens[1];
  assign min_units  = funits[1];
  assign hour_tens  = ftens[2];
  assign hour_units = funits[2];
endmodule

// File: rtl/tod_checker.sv
module tod_checker
  import tod_pkg::*;
#(
  parameter bit COUNT_UP = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] adj_sel,
  input logic       adj_plus,
  input logic       adj_minus,
  input logic [4:0] hours,
  input logic [5:0] minutes,
  input logic [5:0] seconds,
  input logic [3:0] sec_tens,
  input logic [3:0] sec_units
);
  localparam logic [5:0] S_TERM  = COUNT_UP ? 6'd59 : 6'd0;
  localparam logic [5:0] S_START = COUNT_UP ? 6'd0  : 6'd59;

  // R9: field ranges
  p_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (seconds <= 6'd59) && (minutes <= 6'd59) && (hours <= 5'd23));

  // R5: simultaneous plus and minus leave seconds unchanged
  p_both_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_sel == SEL_SEC && adj_plus && adj_minus) |=> $stable(seconds));

  // R4: plus alone on seconds adds one below the maximum
  p_plus_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_sel == SEL_SEC && adj_plus && !adj_minus && seconds != 6'd59)
      |=> seconds == $past(seconds) + 6'd1);

  // R6: adjusting seconds never disturbs minutes or hours
  p_adj_no_carry_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (adj_sel == SEL_SEC && (adj_plus || adj_minus))
      |=> ($stable(minutes) && $stable(hours)));

  // R3: minutes move without their own adjust only when seconds wrap
  p_min_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(minutes) && !$past(adj_sel == SEL_MIN && (adj_plus || adj_minus)))
      |-> ($past(seconds) == S_TERM && seconds == S_START));

  // R8: digit split is consistent with the binary seconds value
  p_digits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (6'(sec_tens) * 6'd10 + 6'(sec_units)) == seconds && sec_units < 4'd10);
endmodule

bind tod_counter tod_checker #(.COUNT_UP(COUNT_UP)) u_tod_chk (
  .clk(clk), .rst_n(rst_n), .adj_sel(adj_sel), .adj_plus(adj_plus),
  .adj_minus(adj_minus), .hours(hours), .minutes(minutes),
  .seconds(seconds), .sec_tens(sec_tens), .sec_units(sec_units)
);

// File: tb/test_tod_counter.sv
module test_tod_counter;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] adj_sel;
  logic       adj_plus, adj_minus;

  logic [4:0] hr   [2];
  logic [5:0] mn   [2];
  logic [5:0] sc   [2];
  logic [3:0] ht [2], hu [2], mt [2], mu [2], st [2], su [2];

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int es [2], em [2], eh [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  tod_counter #(.TICK_DIV(DIV), .COUNT_UP(1'b1)) i_tod_counter (
    .clk(clk), .rst_n(rst_n), .adj_sel(adj_sel), .adj_plus(adj_plus),
    .adj_minus(adj_minus), .hours(hr[0]), .minutes(mn[0]), .seconds(sc[0]),
    .hour_tens(ht[0]), .hour_units(hu[0]), .min_tens(mt[0]),
    .min_units(mu[0]), .sec_tens(st[0]), .sec_units(su[0]));

  tod_counter #(.TICK_DIV(DIV), .COUNT_UP(1'b0)) i_tod_counter_dn (
    .clk(clk), .rst_n(rst_n), .adj_sel(adj_sel), .adj_plus(adj_plus),
    .adj_minus(adj_minus), .hours(hr[1]), .minutes(mn[1]), .seconds(sc[1]),
    .hour_tens(ht[1]), .hour_units(hu[1]), .min_tens(mt[1]),
    .min_units(mu[1]), .sec_tens(st[1]), .sec_units(su[1]));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic compare(string tag);
    for (int d = 0; d < 2; d++) begin
      chk(tag, d ? "dn seconds" : "up seconds", int'(sc[d]), es[d]);
      chk(tag, d ? "dn minutes" : "up minutes", int'(mn[d]), em[d]);
      chk(tag, d ? "dn hours"   : "up hours",   int'(hr[d]), eh[d]);
      chk("R8", "sec digits", int'(st[d]) * 16 + int'(su[d]), (es[d] / 10) * 16 + es[d] % 10);
      chk("R8", "min digits", int'(mt[d]) * 16 + int'(mu[d]), (em[d] / 10) * 16 + em[d] % 10);
      chk("R8", "hour digits", int'(ht[d]) * 16 + int'(hu[d]), (eh[d] / 10) * 16 + eh[d] % 10);
      chk("R9", "range", int'(sc[d] <= 59 && mn[d] <= 59 && hr[d] <= 23), 1);
    end
  endtask

  function automatic int wrap_step(int v, int mx, bit up);
    if (up) return (v == mx) ? 0 : v + 1;
    return (v == 0) ? mx : v - 1;
  endfunction

  // Model one field: returns new value, sets carry out
  function automatic int fld(int v, int mx, bit sel, bit p, bit m, bit en, bit up, output bit co);
    co = 1'b0;
    if (sel && p && !m) return wrap_step(v, mx, 1'b1);
    if (sel && m && !p) return wrap_step(v, mx, 1'b0);
    if (sel && p && m)  return v;
    if (en) begin
      co = up ? (v == mx) : (v == 0);
      return wrap_step(v, mx, up);
    end
    return v;
  endfunction

  task automatic model_edge(logic [1:0] s, bit p, bit m);
    bit tick, c1, c2, c3;
    tick = (cyc % DIV) == 0;
    for (int d = 0; d < 2; d++) begin
      bit up;
      up = (d == 0);
      es[d] = fld(es[d], 59, s == 2'd0, p, m, tick, up, c1);
      em[d] = fld(em[d], 59, s == 2'd1, p, m, c1,   up, c2);
      eh[d] = fld(eh[d], 23, s == 2'd2, p, m, c2,   up, c3);
    end
    cyc++;
  endtask

  // Called at a falling edge; applies inputs for the next rising edge
  task automatic step(string tag, logic [1:0] s, bit p, bit m);
    adj_sel = s; adj_plus = p; adj_minus = m;
    @(posedge clk);
    model_edge(s, p, m);
    @(negedge clk);
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    rst_n = 1'b0; adj_sel = 2'd3; adj_plus = 1'b0; adj_minus = 1'b0;
    for (int d = 0; d < 2; d++) begin es[d] = 0; em[d] = 0; eh[d] = 0; end
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;

    // R2 first tick right after reset; R7 down instance goes to 23:59:59
    step("R2", 2'd3, 1'b0, 1'b0);
    chk("R7", "dn wrap after first tick", int'(hr[1]) * 3600 + int'(mn[1]) * 60 + int'(sc[1]), 86399);
    chk("R2", "up first tick", int'(sc[0]), 1);
    // R2/R3 free run across a minute boundary
    for (int i = 0; i < 300; i++) step("R2", 2'd3, 1'b0, 1'b0);

    // R4 plus and minus sweeps on each field, crossing wraps
    for (int i = 0; i < 70; i++) step("R4", 2'd0, 1'b1, 1'b0);
    for (int i = 0; i < 70; i++) step("R4", 2'd0, 1'b0, 1'b1);
    for (int i = 0; i < 65; i++) step("R4", 2'd1, 1'b1, 1'b0);
    for (int i = 0; i < 65; i++) step("R4", 2'd1, 1'b0, 1'b1);
    for (int i = 0; i < 30; i++) step("R4", 2'd2, 1'b1, 1'b0);
    for (int i = 0; i < 30; i++) step("R4", 2'd2, 1'b0, 1'b1);

    // R5 both pulses together, and select 3 reaching no field
    for (int f = 0; f < 3; f++)
      for (int i = 0; i < 20; i++) step("R5", 2'(f), 1'b1, 1'b1);
    for (int i = 0; i < 20; i++) step("R5", 2'd3, 1'b1, 1'b0);
    for (int i = 0; i < 20; i++) step("R5", 2'd3, 1'b0, 1'b1);

    // R3 set up 23:59:57 on the up instance, then run over midnight
    while (eh[0] != 23) step("R4", 2'd2, 1'b0, 1'b1);
    while (em[0] != 59) step("R4", 2'd1, 1'b0, 1'b1);
    while (es[0] != 57) step("R4", 2'd0, 1'b1, 1'b0);
    for (int i = 0; i < 16; i++) step("R3", 2'd3, 1'b0, 1'b0);
    chk("R3", "up after midnight", int'(hr[0]) * 3600 + int'(mn[0]) * 60 + int'(sc[0]), es[0]);
    chk("R3", "up hours wrapped to 0", int'(hr[0]), 0);

    // R6 pseudo-random adjusts colliding with ticks
    lfsr = 16'hACE1;
    for (int i = 0; i < 6000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step("R6", lfsr[1:0], lfsr[4] & lfsr[2], lfsr[5] & lfsr[3]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule